// File: doc/BRIEF.md
# Countdown Watchdog Timer with Register Interface

This block is a watchdog that raises a system reset request when software stops servicing it. It has two 32-bit word registers on a simple write-strobe bus: a live count word at byte address 0 and a control word at byte address 4. Software starts the watchdog by writing a nonzero tick count. It services the watchdog by writing a fresh count of two or more, and it halts the watchdog by writing zero. The count word always reads back the remaining ticks. The terminal value is one, not zero. A zero count means the watchdog is idle, and writing one requests a reset at once. Software uses that write as a restart.

The control word holds two bits. Bit 0 picks which single-cycle tick pulse decrements the counter: the crystal-derived pulse when the bit is set, and the alternate pulse when it is clear. Bit 31 is a mask. While it is set, the reset request output stays low, but the counter keeps following its normal rules. After block reset the mask is set.

A small state machine sits alongside the counter. Its states are `WD_STOPPED` (count 0), `WD_COUNTING` (count of two or more) and `WD_EXPIRED` (count 1). It has five transitions:
- ARM: from stopped to counting, on a write of two or more.
- EXPIRE: from counting to expired, on a selected tick while the count is 2.
- FIRE: into expired from any state, on a write of 1.
- KICK: into counting from any state, on a write of two or more.
- STOP: into stopped from any state, on a write of 0.

Top module: `tick_watchdog`

## Requirements
- R1: After block reset the count word reads 0, the control word reads 0x8000_0000 and `reset_req` is low.
- R2: A bus write to byte address 0 loads the written 32-bit value into the counter, and the new value reads back from address 0 in the following cycle.
- R3: While the count is 2 or more and no count write occurs, each pulse on the selected tick input lowers the count by exactly one. A pulse on the unselected input leaves the count unchanged.
- R4: Control bit 0 picks the tick source: 1 selects `tick_xtal`, 0 selects `tick_alt`.
- R5: A count of 0 never changes on ticks, and `reset_req` stays low while the count is 0.
- R6: A selected tick at count 2 brings the count to 1, and `reset_req` rises after that same clock edge. Further ticks leave the count at 1.
- R7: Writing 1 to the count word while control bit 31 is clear raises `reset_req` after the write edge.
- R8: Once high, `reset_req` stays high until the count word is written with 0 or with a value of 2 or more. It falls after that write edge.
- R9: While control bit 31 is set, `reset_req` is low whatever the count. Clearing the bit while the count is 1 raises `reset_req` after that control write.
- R10: When a count write and a selected tick fall in the same cycle, the written value is loaded and no decrement occurs.
- R11: The control word stores only bits 31 and 0, and its other bits read as 0. Any byte address other than 0 and 4 ignores writes and reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address for the write and the read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_xtal | input | 1 | Tick pulse from the crystal-derived source |
| tick_alt | input | 1 | Tick pulse from the alternate source |
| reset_req | output | 1 | Registered system reset request |

## Verification
Every result is due one clock edge after its cause. The count word and the control word change on the edge that takes the write or the tick. `reset_req` is registered from the same next-state values, so it changes on that same edge and does not lag behind the count. Read data is combinational, so a read reflects the edge just passed. The bench applies each stimulus for exactly one edge and drops it straight after that edge. It then compares read data and `reset_req` in a later clock-low phase with no strobe or tick active, so every compared value is frozen and sits exactly one edge behind the stimulus.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int BUS_W       = 32;
    localparam int SRC_BIT     = 0;
    localparam int MASK_BIT    = 31;
    localparam int CNT_OFFSET  = 0;
    localparam int CTRL_OFFSET = 4;
    localparam logic [BUS_W-1:0] CTRL_RESET = 32'h8000_0000;

    typedef enum logic [1:0] {
        WD_STOPPED  = 2'd0,
        WD_COUNTING = 2'd1,
        WD_EXPIRED  = 2'd2
    } wd_state_e;

    // Map a loaded count value onto the state it places the machine in
    function automatic wd_state_e state_of(input logic [BUS_W-1:0] v);
        if (v == '0)
            return WD_STOPPED;
        else if (v == {{(BUS_W-1){1'b0}}, 1'b1})
            return WD_EXPIRED;
        else
            return WD_COUNTING;
    endfunction

endpackage

// File: rtl/wdt_decode.sv
module wdt_decode #(
    parameter int ADDR_W = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              cnt_sel,
    output logic              ctrl_sel,
    output logic              cnt_wr,
    output logic              ctrl_wr
);
    import wdt_pkg::*;

    localparam logic [ADDR_W-1:0] CNT_A  = ADDR_W'(CNT_OFFSET);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFFSET);

    always_comb begin
        cnt_sel  = (addr == CNT_A);
        ctrl_sel = (addr == CTRL_A);
        cnt_wr   = wr_en && cnt_sel;
        ctrl_wr  = wr_en && ctrl_sel;
    end

endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic wr_src,
    input  logic wr_mask,
    output logic src_xtal,
    output logic mask_q,
    output logic mask_nxt
);
    import wdt_pkg::*;

    logic src_nxt;

    always_comb begin
        src_nxt  = ctrl_wr ? wr_src  : src_xtal;
        mask_nxt = ctrl_wr ? wr_mask : mask_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_xtal <= CTRL_RESET[SRC_BIT];
            mask_q   <= CTRL_RESET[MASK_BIT];
        end else begin
            src_xtal <= src_nxt;
            mask_q   <= mask_nxt;
        end
    end

endmodule

// File: rtl/wdt_tick_mux.sv
module wdt_tick_mux #(
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0] ticks,
    input  logic               sel,
    output logic               tick
);
    // Index 1 is the crystal pulse, index 0 the alternate pulse
    generate
        if (NUM_SRC == 1) begin : g_single
            logic unused_sel;
            assign unused_sel = sel;
            assign tick = ticks[0];
        end else begin : g_pair
            assign tick = sel ? ticks[1] : ticks[0];
        end
    endgenerate

endmodule

// File: rtl/wdt_core.sv
module wdt_core (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cnt_wr,
    input  logic [wdt_pkg::BUS_W-1:0] wdata,
    input  logic                      tick,
    input  logic                      mask_nxt,
    output logic [wdt_pkg::BUS_W-1:0] cnt_q,
    output wdt_pkg::wd_state_e        state_q,
    output logic                      reset_req
);
    import wdt_pkg::*;

    localparam logic [BUS_W-1:0] TWO = BUS_W'(2);
    localparam logic [BUS_W-1:0] ONE = BUS_W'(1);

    logic [BUS_W-1:0] cnt_nxt;
    wd_state_e        state_nxt;

    // Next-state and next-count logic
    always_comb begin
        cnt_nxt   = cnt_q;
        state_nxt = state_q;
        if (cnt_wr) begin
            // ARM / KICK / FIRE / STOP, decided by the written value
            cnt_nxt   = wdata;
            state_nxt = state_of(wdata);
        end else begin
            unique case (state_q)
                WD_STOPPED: begin
                    state_nxt = WD_STOPPED;
                end
                WD_COUNTING: begin
                    if (tick) begin
                        cnt_nxt = cnt_q - ONE;
                        if (cnt_q == TWO)
                            state_nxt = WD_EXPIRED;   // EXPIRE
                    end
                end
                WD_EXPIRED: begin
                    state_nxt = WD_EXPIRED;
                end
                default: begin
                    state_nxt = WD_STOPPED;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_STOPPED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nxt;
            cnt_q   <= cnt_nxt;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n)
            reset_req <= 1'b0;
        else
            reset_req <= (state_nxt == WD_EXPIRED) && !mask_nxt;
    end

endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_xtal,
    input  logic              tick_alt,
    output logic              reset_req
);
    import wdt_pkg::*;

    logic             cnt_sel, ctrl_sel, cnt_wr, ctrl_wr;
    logic             src_xtal, mask_q, mask_nxt;
    logic             tick_sel;
    logic [BUS_W-1:0] cnt_live;
    wd_state_e        fsm_state;

    wdt_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en    (bus_wr_en),
        .addr     (bus_addr),
        .cnt_sel  (cnt_sel),
        .ctrl_sel (ctrl_sel),
        .cnt_wr   (cnt_wr),
        .ctrl_wr  (ctrl_wr)
    );

    wdt_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .wr_src   (bus_wdata[SRC_BIT]),
        .wr_mask  (bus_wdata[MASK_BIT]),
        .src_xtal (src_xtal),
        .mask_q   (mask_q),
        .mask_nxt (mask_nxt)
    );

    wdt_tick_mux #(.NUM_SRC(2)) u_mux (
        .ticks ({tick_xtal, tick_alt}),
        .sel   (src_xtal),
        .tick  (tick_sel)
    );

    wdt_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_wr    (cnt_wr),
        .wdata     (bus_wdata),
        .tick      (tick_sel),
        .mask_nxt  (mask_nxt),
        .cnt_q     (cnt_live),
        .state_q   (fsm_state),
        .reset_req (reset_req)
    );

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (cnt_sel)
            bus_rdata = cnt_live;
        else if (ctrl_sel) begin
            bus_rdata[SRC_BIT]  = src_xtal;
            bus_rdata[MASK_BIT] = mask_q;
        end
    end

endmodule

// File: rtl/tick_watchdog_chk.sv
module tick_watchdog_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              reset_req,
    input logic [31:0]       cnt_live,
    input logic              mask_q,
    input logic              tick_sel
);
    logic cnt_write;
    assign cnt_write = bus_wr_en && (bus_addr == '0);

    // R5: an idle counter stays idle without a count write
    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_live == 32'd0 && !cnt_write) |=> (cnt_live == 32'd0));

    // R3: a selected tick lowers a count of two or more by one
    assert_tick_decrements_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_live >= 32'd2 && !cnt_write && tick_sel) |=> (cnt_live == $past(cnt_live) - 32'd1));

    // R6: the request only ever appears at the terminal count
    assert_req_at_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (cnt_live == 32'd1));

    // R7: writing 1 while unmasked fires the request
    assert_write_one_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_write && bus_wdata == 32'd1 && !mask_q) |=> reset_req);

    // R8: without any bus write the request persists
    assert_req_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && !bus_wr_en) |=> reset_req);

    // R9: the mask keeps the request low
    assert_mask_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |-> !reset_req);

endmodule

bind tick_watchdog tick_watchdog_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .reset_req (reset_req),
    .cnt_live  (cnt_live),
    .mask_q    (mask_q),
    .tick_sel  (tick_sel)
);

// File: tb/tick_watchdog_tb_top.sv
module tick_watchdog_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr_en = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          tick_xtal = 1'b0;
    logic          tick_alt = 1'b0;
    logic          reset_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_watchdog #(.ADDR_W(AW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_xtal (tick_xtal),
        .tick_alt  (tick_alt),
        .reset_req (reset_req)
    );

    typedef struct {
        string       req;
        logic [31:0] exp_rd;
        logic        exp_rst;
    } item_t;

    item_t queue_q[$];
    event  chk_ev;
    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    // Reference model kept from the requirements
    logic [31:0] m_cnt = '0;
    logic        m_src = 1'b0;
    logic        m_mask = 1'b1;

    function automatic logic m_rst();
        return (m_cnt == 32'd1) && !m_mask;
    endfunction

    // Monitor: compare outputs as expectations arrive
    initial begin
        forever begin
            @(chk_ev);
            while (queue_q.size() > 0) begin
                item_t it;
                it = queue_q.pop_front();
                n_vec++;
                if (bus_rdata !== it.exp_rd || reset_req !== it.exp_rst) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%h reset_req=%b expected rdata=%h reset_req=%b",
                             it.req, bus_rdata, reset_req, it.exp_rd, it.exp_rst);
                end
            end
        end
    end

    // One bus/tick cycle, then the model follows the same edge
    task automatic drive(input logic wr, input logic [AW-1:0] a, input logic [31:0] d,
                         input logic tx, input logic ta);
        logic sel_t;
        @(negedge clk);
        bus_wr_en = wr; bus_addr = a; bus_wdata = d; tick_xtal = tx; tick_alt = ta;
        @(posedge clk);
        sel_t = m_src ? tx : ta;
        if (wr && a == 4'd0)
            m_cnt = d;
        else if (sel_t && m_cnt >= 32'd2)
            m_cnt = m_cnt - 32'd1;
        if (wr && a == 4'd4) begin
            m_src  = d[0];
            m_mask = d[31];
        end
        #1;
        bus_wr_en = 1'b0; tick_xtal = 1'b0; tick_alt = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        drive(1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic tick(input logic tx, input logic ta);
        drive(1'b0, 4'd0, 32'd0, tx, ta);
    endtask

    // Driver: push the expectation for a read of address a
    task automatic check(input string req, input logic [AW-1:0] a);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        #1;
        it.req = req;
        if (a == 4'd0)      it.exp_rd = m_cnt;
        else if (a == 4'd4) it.exp_rd = {m_mask, 30'd0, m_src};
        else                it.exp_rd = 32'd0;
        it.exp_rst = m_rst();
        queue_q.push_back(it);
        -> chk_ev;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 count after reset", 4'd0);
        check("R1 control after reset", 4'd4);

        // R5: idle counter ignores ticks
        tick(1'b1, 1'b1);
        tick(1'b1, 1'b1);
        check("R5 idle ignores ticks", 4'd0);

        // R11: only bits 31 and 0 stored
        wr(4'd4, 32'hFFFF_FFFF);
        check("R11 control keeps two bits", 4'd4);
        wr(4'd4, 32'h0000_0001);
        check("R11 control select only", 4'd4);

        // R2, R3, R4 with crystal source selected
        wr(4'd0, 32'd5);
        check("R2 count loaded", 4'd0);
        tick(1'b0, 1'b1);
        check("R4 alternate ignored when crystal selected", 4'd0);
        tick(1'b1, 1'b0);
        check("R3 one decrement", 4'd0);
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        check("R3 count at two, no request", 4'd0);
        tick(1'b1, 1'b0);
        check("R6 terminal count fires", 4'd0);
        tick(1'b1, 1'b1);
        check("R6 holds at one, R8 request sticky", 4'd0);

        // R8: kick clears request
        wr(4'd0, 32'd10);
        check("R8 kick clears request", 4'd0);

        // R4: alternate source
        wr(4'd4, 32'h0000_0000);
        tick(1'b1, 1'b0);
        check("R4 crystal ignored when alternate selected", 4'd0);
        tick(1'b0, 1'b1);
        check("R4 alternate decrements", 4'd0);

        // R10: write beats simultaneous tick
        drive(1'b1, 4'd0, 32'd7, 1'b0, 1'b1);
        check("R10 write wins over tick", 4'd0);

        // R7 / R8
        wr(4'd0, 32'd1);
        check("R7 write one fires", 4'd0);
        wr(4'd0, 32'd0);
        check("R8 stop clears request", 4'd0);
        tick(1'b1, 1'b1);
        check("R5 stopped stays zero", 4'd0);

        // R9: mask
        wr(4'd4, 32'h8000_0000);
        wr(4'd0, 32'd1);
        check("R9 masked request low", 4'd0);
        wr(4'd4, 32'h0000_0000);
        check("R9 unmask at one fires", 4'd0);
        wr(4'd4, 32'h8000_0000);
        check("R9 remask drops request", 4'd0);
        wr(4'd0, 32'd0);

        // R11: unmapped address
        wr(4'd0, 32'd3);
        wr(4'd8, 32'h0000_0055);
        check("R11 unmapped read zero", 4'd8);
        check("R11 unmapped write left count", 4'd0);
        check("R11 unmapped write left control", 4'd4);
        wr(4'd2, 32'd9);
        check("R11 misaligned write ignored", 4'd0);

        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule